// File: doc/BRIEF.md
# Converter Data-Ready Line Controller

This block drives the active-low "new data available" line that a four-channel sampling converter presents to its host. Each channel reports the end of its own conversion with a one-cycle strobe. The channels carry signed phase-trim settings, so their strobes arrive at different times within a sample period. The block decides which strobes count as a new-data event. It can follow the channel with the most positive trim, every enabled channel, or the channel with the most negative trim. It then shows the event on the line as a held level or as a short pulse.

After a restart (channels newly enabled or a sync pulse), the block can defer the first indication by one sample period. It defers when the controlling channel's trim is at or below a limit that depends on the oversampling ratio. In pulse format it tracks whether the host read the last result. An unread result causes the next event to be skipped. Events that land while a host read is in progress are swallowed. An output-enable lets the line idle released, for a wired open-drain connection with an external pull-up.

Top module: `ready_line_ctrl`

## Requirements
- R1: After reset `ready_n` is 1 and, with `hiz_idle` = 0, `ready_oe` is 1.
- R2: With `src_sel` = 2'b00 the event is the strobe of the enabled channel with the largest signed phase. Ties go to the lowest index, and strobes of other or disabled channels are ignored.
- R3: With `src_sel` = 2'b01 a strobe from any enabled channel is an event, and strobes from disabled channels are ignored.
- R4: With `src_sel` = 2'b10 or 2'b11 the event is the strobe of the enabled channel with the smallest signed phase, with ties going to the lowest index.
- R5: With `gchop` = 1, phases are treated as zero. The event is the strobe of the lowest-index enabled channel, whatever `src_sel` holds.
- R6: After `restart`, the first event is dropped when the controlling phase is at or below (signed) the limit 45 − (32 << `ratio_code`) for `ratio_code` 0..4. Ratio code 0 (ratio 64) gives +13 and code 4 (ratio 1024) gives −467. For codes 00/1x the controlling phase is the trim of the selected channel; for code 01 it is the most negative enabled phase.
- R7: For `ratio_code` 5..7 (ratio above 1024) the first event after `restart` is never dropped.
- R8: With `pulse_fmt` = 0, `ready_n` goes low in the cycle after an event. It stays low, including through `rd_start`, until `rd_done` is seen, and goes high in the cycle after `rd_done`.
- R9: With `pulse_fmt` = 0, an event while the line is already low raises `ready_n` for exactly one cycle, after which it is low again.
- R10: With `pulse_fmt` = 1, an event drives `ready_n` low for PULSE_LEN (default 2) cycles, starting in the cycle after the event. It never goes low without an event.
- R11: With `pulse_fmt` = 1, if no `rd_done` follows a pulse, the next event produces no pulse, and the event after that pulses again.
- R12: With `pulse_fmt` = 1, an event arriving after `rd_start` and before `rd_done` produces no pulse.
- R13: With `hiz_idle` = 1, `ready_oe` is 0 whenever `ready_n` is 1. A low on `ready_n` is always driven (`ready_oe` = 1).
- R14: `restart` returns `ready_n` high in the next cycle and clears the unread tracking, so the next event pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_done | input | NCH | Per-channel conversion-complete strobes |
| ch_en | input | NCH | Per-channel enables |
| phase_flat | input | NCH*PW | Signed phase trims, channel 0 in the low bits |
| ratio_code | input | 3 | Oversampling ratio: 0=64, 1=128, 2=256, 3=512, 4=1024, 5..7=above 1024 |
| src_sel | input | 2 | Event source: 00 most lagging, 01 any, 1x most leading |
| pulse_fmt | input | 1 | 0 level format, 1 pulse format |
| hiz_idle | input | 1 | Release the line when idle |
| gchop | input | 1 | Global-chop mode active |
| restart | input | 1 | Channel enable or sync event |
| rd_start | input | 1 | Host begins reading data |
| rd_done | input | 1 | Host has shifted out all data |
| ready_n | output | 1 | Active-low data-ready line |
| ready_oe | output | 1 | Output enable for the line |

## Verification
The hardest state to reach is the one where the deferred first event after a restart meets the signed limit exactly. Reaching it needs the right ratio code together with the trim of whichever channel currently controls the line. The bench therefore restarts with a single enabled channel and sets its trim to the limit and to one above it, at both ends of the ratio range. It counts a silent strobe before the first falling edge. The pulse-format skip and read-blocking cases are reached by leaving a pulse unread, or by opening a read window before the strobe. The bench then checks that the line stays high on the strobe and that the next strobe pulses.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

  typedef enum logic [1:0] {
    SRC_LAG      = 2'b00,
    SRC_ANY      = 2'b01,
    SRC_LEAD     = 2'b10,
    SRC_LEAD_ALT = 2'b11
  } src_sel_e;

  localparam int unsigned LIMIT_W       = 16;
  localparam logic [2:0]  TOP_RATIO_CODE = 3'd4;

  // Deferral limit per ratio code: doubles its distance below +45 per step.
  function automatic logic signed [LIMIT_W-1:0] phase_limit(input logic [2:0] code);
    logic signed [LIMIT_W-1:0] step;
    step = 16'sd32 <<< code;
    return 16'sd45 - step;
  endfunction

  function automatic logic limit_exists(input logic [2:0] code);
    return code <= TOP_RATIO_CODE;
  endfunction

endpackage

// File: rtl/rlc_src_pick.sv
module rlc_src_pick
  import rlc_pkg::*;
#(
  parameter int NCH = 4,
  parameter int PW  = 10
) (
  input  logic [NCH-1:0]           done,
  input  logic [NCH-1:0]           en,
  input  logic [NCH*PW-1:0]        phase_flat,
  input  logic [1:0]               src_sel,
  input  logic                     gchop,
  output logic                     ev_raw,
  output logic signed [PW-1:0]     ctrl_phase
);

  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [IW-1:0]        lag_idx, lead_idx, first_idx;
  logic signed [PW-1:0] lag_v, lead_v, ph;
  logic                 any_en;
  src_sel_e             sel;

  // Signed max / min search over enabled channels; strict compare keeps
  // the lowest index on ties.
  always_comb begin
    lag_idx   = '0;
    lead_idx  = '0;
    first_idx = '0;
    lag_v     = '0;
    lead_v    = '0;
    any_en    = 1'b0;
    ph        = '0;
    for (int i = 0; i < NCH; i++) begin
      ph = $signed(phase_flat[i*PW +: PW]);
      if (en[i]) begin
        if (!any_en) begin
          lag_idx   = IW'(i);
          lead_idx  = IW'(i);
          first_idx = IW'(i);
          lag_v     = ph;
          lead_v    = ph;
          any_en    = 1'b1;
        end else begin
          if (ph > lag_v) begin
            lag_idx = IW'(i);
            lag_v   = ph;
          end
          if (ph < lead_v) begin
            lead_idx = IW'(i);
            lead_v   = ph;
          end
        end
      end
    end
  end

  always_comb begin
    sel = src_sel_e'(src_sel);
    if (gchop) begin
      ev_raw     = any_en & done[first_idx];
      ctrl_phase = '0;
    end else begin
      unique case (sel)
        SRC_LAG: begin
          ev_raw     = any_en & done[lag_idx];
          ctrl_phase = lag_v;
        end
        SRC_ANY: begin
          ev_raw     = |(done & en);
          ctrl_phase = lead_v;
        end
        default: begin
          ev_raw     = any_en & done[lead_idx];
          ctrl_phase = lead_v;
        end
      endcase
    end
  end

endmodule

// File: rtl/rlc_first_gate.sv
module rlc_first_gate
  import rlc_pkg::*;
#(
  parameter int PW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart,
  input  logic                 ev_raw,
  input  logic signed [PW-1:0] ctrl_phase,
  input  logic [2:0]           ratio_code,
  output logic                 ev_ok
);

  logic signed [LIMIT_W-1:0] phase_ext;
  logic                      defer_cond;
  logic                      defer_q, defer_d, defer_en;

  always_comb begin
    phase_ext  = LIMIT_W'(ctrl_phase);
    defer_cond = limit_exists(ratio_code) && (phase_ext <= phase_limit(ratio_code));
    defer_en   = restart | ev_raw;
    if (restart) defer_d = defer_cond;
    else         defer_d = 1'b0;
    ev_ok      = ev_raw & ~defer_q & ~restart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        defer_q <= 1'b0;
    else if (defer_en) defer_q <= defer_d;
  end

endmodule

// File: rtl/rlc_line_fmt.sv
module rlc_line_fmt #(
  parameter int PULSE_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic ev,
  input  logic pulse_fmt,
  input  logic rd_start,
  input  logic rd_done,
  output logic line_low
);

  localparam int CW = $clog2(PULSE_LEN + 1);

  logic          low_q, low_d;
  logic          gap_q, gap_d;
  logic [CW-1:0] pcnt_q, pcnt_d;
  logic          unread_q, unread_d;
  logic          reading_q, reading_d;

  // Read window tracking
  always_comb begin
    if (rd_done)       reading_d = 1'b0;
    else if (rd_start) reading_d = 1'b1;
    else               reading_d = reading_q;
  end

  // Level format: hold low until read, one-cycle gap on unread data
  always_comb begin
    low_d = low_q;
    gap_d = 1'b0;
    if (restart) begin
      low_d = 1'b0;
    end else if (ev && !pulse_fmt) begin
      low_d = 1'b1;
      gap_d = low_q & ~gap_q;
    end else if (rd_done) begin
      low_d = 1'b0;
    end
  end

  // Pulse format: fixed-width pulse, skip after unread, block during read
  always_comb begin
    pcnt_d   = (pcnt_q != '0) ? pcnt_q - 1'b1 : '0;
    unread_d = unread_q;
    if (restart) begin
      pcnt_d   = '0;
      unread_d = 1'b0;
    end else begin
      if (rd_done) unread_d = 1'b0;
      if (ev && pulse_fmt && !reading_q) begin
        if (unread_q) begin
          unread_d = 1'b0;
        end else begin
          pcnt_d   = CW'(PULSE_LEN);
          unread_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q     <= 1'b0;
      gap_q     <= 1'b0;
      pcnt_q    <= '0;
      unread_q  <= 1'b0;
      reading_q <= 1'b0;
    end else begin
      low_q     <= low_d;
      gap_q     <= gap_d;
      pcnt_q    <= pcnt_d;
      unread_q  <= unread_d;
      reading_q <= reading_d;
    end
  end

  assign line_low = pulse_fmt ? (pcnt_q != '0) : (low_q & ~gap_q);

endmodule

// File: rtl/ready_line_ctrl.sv
module ready_line_ctrl #(
  parameter int NCH       = 4,
  parameter int PW        = 10,
  parameter int PULSE_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ch_done,
  input  logic [NCH-1:0]    ch_en,
  input  logic [NCH*PW-1:0] phase_flat,
  input  logic [2:0]        ratio_code,
  input  logic [1:0]        src_sel,
  input  logic              pulse_fmt,
  input  logic              hiz_idle,
  input  logic              gchop,
  input  logic              restart,
  input  logic              rd_start,
  input  logic              rd_done,
  output logic              ready_n,
  output logic              ready_oe
);

  logic                 ev_raw, ev_ok, line_low;
  logic signed [PW-1:0] ctrl_phase;

  rlc_src_pick #(.NCH(NCH), .PW(PW)) pick_i (
    .done       (ch_done),
    .en         (ch_en),
    .phase_flat (phase_flat),
    .src_sel    (src_sel),
    .gchop      (gchop),
    .ev_raw     (ev_raw),
    .ctrl_phase (ctrl_phase)
  );

  rlc_first_gate #(.PW(PW)) gate_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .ev_raw     (ev_raw),
    .ctrl_phase (ctrl_phase),
    .ratio_code (ratio_code),
    .ev_ok      (ev_ok)
  );

  rlc_line_fmt #(.PULSE_LEN(PULSE_LEN)) fmt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .ev        (ev_ok),
    .pulse_fmt (pulse_fmt),
    .rd_start  (rd_start),
    .rd_done   (rd_done),
    .line_low  (line_low)
  );

  assign ready_n  = ~line_low;
  assign ready_oe = ~hiz_idle | line_low;

endmodule

// File: rtl/rlc_checker.sv
module rlc_checker #(
  parameter int NCH       = 4,
  parameter int PULSE_LEN = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] ch_done,
  input logic           pulse_fmt,
  input logic           hiz_idle,
  input logic           restart,
  input logic           rd_done,
  input logic           ready_n,
  input logic           ready_oe
);

  p_low_driven_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_n |-> ready_oe);

  p_idle_released_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (hiz_idle && ready_n) |-> !ready_oe);

  p_restart_high_r14: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> ready_n);

  p_level_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_fmt && rd_done && ch_done == '0 && !restart) |=> (pulse_fmt || ready_n));

  p_no_spurious_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_fmt && ch_done == '0) |=> (!pulse_fmt || !$fell(ready_n)));

  generate
    if (PULSE_LEN >= 2) begin : g_hold
      p_pulse_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_fmt && $past(pulse_fmt) && $fell(ready_n) && !restart)
          |=> (!pulse_fmt || !ready_n));
    end
  endgenerate

endmodule

bind ready_line_ctrl rlc_checker #(.NCH(NCH), .PULSE_LEN(PULSE_LEN)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ch_done   (ch_done),
  .pulse_fmt (pulse_fmt),
  .hiz_idle  (hiz_idle),
  .restart   (restart),
  .rd_done   (rd_done),
  .ready_n   (ready_n),
  .ready_oe  (ready_oe)
);

// File: tb/ready_line_ctrl_tb_top.sv
module ready_line_ctrl_tb_top;

  localparam int NCH = 4;
  localparam int PW  = 10;

  logic              clk;
  logic              rst_n;
  logic [NCH-1:0]    ch_done, ch_en;
  logic signed [PW-1:0] ph [NCH];
  logic [NCH*PW-1:0] phase_flat;
  logic [2:0]        ratio_code;
  logic [1:0]        src_sel;
  logic              pulse_fmt, hiz_idle, gchop, restart, rd_start, rd_done;
  logic              ready_n, ready_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  assign phase_flat = {ph[3], ph[2], ph[1], ph[0]};

  ready_line_ctrl #(.NCH(NCH), .PW(PW), .PULSE_LEN(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .ch_done(ch_done), .ch_en(ch_en),
    .phase_flat(phase_flat), .ratio_code(ratio_code), .src_sel(src_sel),
    .pulse_fmt(pulse_fmt), .hiz_idle(hiz_idle), .gchop(gchop),
    .restart(restart), .rd_start(rd_start), .rd_done(rd_done),
    .ready_n(ready_n), .ready_oe(ready_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic fire(logic [NCH-1:0] m);
    ch_done = m;
    step();
    ch_done = '0;
  endtask

  task automatic clear_line();
    rd_done = 1'b1;
    step();
    rd_done = 1'b0;
  endtask

  task automatic full_read();
    rd_start = 1'b1;
    step();
    rd_start = 1'b0;
    rd_done  = 1'b1;
    step();
    rd_done  = 1'b0;
  endtask

  task automatic do_restart();
    restart = 1'b1;
    step();
    restart = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ready_n after reset", ready_n, 1'b1);
    check("R1 ready_oe after reset", ready_oe, 1'b1);
  endtask

  task automatic t_src_lag();
    pulse_fmt = 0; src_sel = 2'b00; ch_en = 4'b1111;
    ph[0] = -10'sd5; ph[1] = 10'sd20; ph[2] = 10'sd20; ph[3] = -10'sd100;
    fire(4'b0100); check("R2 tie loser ignored", ready_n, 1'b1);
    fire(4'b0010); check("R2 lagging channel fires", ready_n, 1'b0);
    clear_line();
    ch_en = 4'b1101;
    fire(4'b0010); check("R2 disabled channel ignored", ready_n, 1'b1);
    fire(4'b0100); check("R2 next lagging fires", ready_n, 1'b0);
    clear_line();
    ch_en = 4'b1111;
  endtask

  task automatic t_src_any();
    src_sel = 2'b01; ch_en = 4'b1011;
    fire(4'b1000); check("R3 any ch3", ready_n, 1'b0);
    clear_line();
    fire(4'b0100); check("R3 disabled ch2 ignored", ready_n, 1'b1);
    fire(4'b0001); check("R3 any ch0", ready_n, 1'b0);
    clear_line();
    ch_en = 4'b1111;
  endtask

  task automatic t_src_lead();
    src_sel = 2'b10;
    fire(4'b0001); check("R4 non-leading ignored", ready_n, 1'b1);
    fire(4'b1000); check("R4 leading fires code 10", ready_n, 1'b0);
    clear_line();
    src_sel = 2'b11;
    fire(4'b0010); check("R4 non-leading ignored code 11", ready_n, 1'b1);
    fire(4'b1000); check("R4 leading fires code 11", ready_n, 1'b0);
    clear_line();
  endtask

  task automatic t_gchop();
    gchop = 1; src_sel = 2'b10; ch_en = 4'b1001;
    fire(4'b1000); check("R5 leading ignored in chop", ready_n, 1'b1);
    fire(4'b0001); check("R5 lowest enabled fires", ready_n, 1'b0);
    clear_line();
    gchop = 0; ch_en = 4'b1111;
  endtask

  task automatic t_defer();
    src_sel = 2'b00; ch_en = 4'b0001; ratio_code = 3'd0;
    ph[0] = 10'sd13; do_restart();
    fire(4'b0001); check("R6 ratio64 at limit deferred", ready_n, 1'b1);
    fire(4'b0001); check("R6 ratio64 second event shown", ready_n, 1'b0);
    clear_line();
    ph[0] = 10'sd14; do_restart();
    fire(4'b0001); check("R6 ratio64 above limit not deferred", ready_n, 1'b0);
    clear_line();
    ratio_code = 3'd4; ph[0] = -10'sd467; do_restart();
    fire(4'b0001); check("R6 ratio1024 at limit deferred", ready_n, 1'b1);
    fire(4'b0001); check("R6 ratio1024 second event", ready_n, 1'b0);
    clear_line();
    ph[0] = -10'sd466; do_restart();
    fire(4'b0001); check("R6 ratio1024 above limit", ready_n, 1'b0);
    clear_line();
    ratio_code = 3'd1; ph[0] = -10'sd19; do_restart();
    fire(4'b0001); check("R6 ratio128 at limit deferred", ready_n, 1'b1);
    clear_line();
  endtask

  task automatic t_nobound();
    ratio_code = 3'd5; ph[0] = -10'sd512; do_restart();
    fire(4'b0001); check("R7 code5 never deferred", ready_n, 1'b0);
    clear_line();
    ratio_code = 3'd7; do_restart();
    fire(4'b0001); check("R7 code7 never deferred", ready_n, 1'b0);
    clear_line();
    ratio_code = 3'd5; ph[0] = '0; ch_en = 4'b1111;
  endtask

  task automatic t_level();
    pulse_fmt = 0; src_sel = 2'b01;
    fire(4'b0001); check("R8 falls after event", ready_n, 1'b0);
    step(); step(); check("R8 held low", ready_n, 1'b0);
    rd_start = 1; step(); rd_start = 0;
    check("R8 still low during read", ready_n, 1'b0);
    clear_line(); check("R8 high after read done", ready_n, 1'b1);
  endtask

  task automatic t_level_gap();
    fire(4'b0001); check("R9 low", ready_n, 1'b0);
    fire(4'b0001); check("R9 gap high", ready_n, 1'b1);
    step(); check("R9 low after gap", ready_n, 1'b0);
    clear_line();
  endtask

  task automatic t_pulse();
    pulse_fmt = 1;
    step(); check("R10 idle in pulse mode", ready_n, 1'b1);
    fire(4'b0001); check("R10 pulse cycle 1", ready_n, 1'b0);
    step(); check("R10 pulse cycle 2", ready_n, 1'b0);
    step(); check("R10 pulse ended", ready_n, 1'b1);
    full_read();
  endtask

  task automatic t_pulse_skip();
    fire(4'b0001); check("R11 first pulse", ready_n, 1'b0);
    step(); step();
    fire(4'b0001); check("R11 unread result skipped", ready_n, 1'b1);
    step(); check("R11 still high", ready_n, 1'b1);
    fire(4'b0001); check("R11 pulsing resumes", ready_n, 1'b0);
    step(); step();
    full_read();
  endtask

  task automatic t_pulse_block();
    rd_start = 1; step(); rd_start = 0;
    fire(4'b0001); check("R12 blocked during read", ready_n, 1'b1);
    step(); check("R12 still high", ready_n, 1'b1);
    clear_line();
    fire(4'b0001); check("R12 pulse after read", ready_n, 1'b0);
    step(); step();
    full_read();
  endtask

  task automatic t_hiz();
    pulse_fmt = 0; hiz_idle = 1;
    step(); check("R13 released when idle", ready_oe, 1'b0);
    fire(4'b0001);
    check("R13 low driven", ready_n, 1'b0);
    check("R13 oe on when low", ready_oe, 1'b1);
    clear_line(); check("R13 released after read", ready_oe, 1'b0);
    hiz_idle = 0;
  endtask

  task automatic t_restart();
    pulse_fmt = 0;
    fire(4'b0001); check("R14 level low", ready_n, 1'b0);
    do_restart(); check("R14 restart raises line", ready_n, 1'b1);
    pulse_fmt = 1;
    fire(4'b0001); step(); step();
    do_restart();
    fire(4'b0001); check("R14 unread cleared, pulses", ready_n, 1'b0);
    step(); step();
    full_read();
  endtask

  initial begin
    for (int w = 0; w < 100000; w++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ch_done = '0; ch_en = 4'b1111;
    for (int i = 0; i < NCH; i++) ph[i] = '0;
    ratio_code = 3'd5; src_sel = 2'b00; pulse_fmt = 0; hiz_idle = 0;
    gchop = 0; restart = 0; rd_start = 0; rd_done = 0;
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_src_lag();
    t_src_any();
    t_src_lead();
    t_gchop();
    t_defer();
    t_nobound();
    t_level();
    t_level_gap();
    t_pulse();
    t_pulse_skip();
    t_pulse_block();
    t_hiz();
    t_restart();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule